// File: doc/BRIEF.md
# Multiplexed Local Bus Cycle Sequencer

This block runs one bus cycle at a time on a 16-bit bus that carries both address and data on the same pins. Each cycle passes through the states T1, T2, T3, zero or more wait states TW, and T4. The bus carries the address in T1 and data in T2 to T4. The four pins above the shared bus carry the top address bits in T1 and a cycle-status code after T1. A pair of lane signals (bus-high-enable, active low, and address bit 0) marks the cycle as a word transfer, an upper-byte transfer, a lower-byte transfer or a memory refresh. The address-latch strobe is produced on falling clock edges, so it leads T1 by half a clock. The read strobe waits half a clock into T2, until the shared bus has been released. An external ready input stretches the cycle with wait states.

A requester offers one cycle at a time: a 20-bit address, a write flag, two byte enables, a DMA flag, a refresh flag and write data. The request is taken in IDLE or in T4, so back-to-back cycles run with no idle gap. For reads, the data on the shared bus is captured at the clock edge that leaves the last T3 or TW. It is returned with a one-cycle done pulse during T4. In queue-status mode the latch and write pins stop carrying their strobes. They show a registered two-bit code about the instruction queue instead, and bus cycles keep running on the remaining pins.

States and transitions: IDLE→T1 when a request is valid, otherwise IDLE holds; T1→T2 always; T2→T3 always; T3→T4 when ready is high, T3→TW when ready is low; TW→TW while ready is low, TW→T4 when ready is high; T4→T1 when a request is valid, otherwise T4→IDLE.

Top module: `lbus_seq`

## Requirements
- R1: A request accepted in IDLE or T4 makes the next cycle T1, followed by T2 and T3. The cycle then spends one TW per clock edge that samples `bus_ready` low at the end of T3 or TW, and enters T4 at the first edge that samples it high. After T4 the state is IDLE, or T1 if a request is valid.
- R2: In T1, `ad_oe` is 1 and `ad_out` carries address bits 15..1 with the lane bit A0 in bit 0. In T2, T3, TW and T4 of a write, `ad_oe` is 1 and `ad_out` carries the write data. In T2 to T4 of a read and in IDLE, `ad_oe` is 0.
- R3: In T1, `a_hi` equals address bits 19..16. In T2, T3, TW and T4, `a_hi` is {dma, 0, 0, 0}: bit 3 is 1 for a DMA cycle and 0 for a processor cycle. In IDLE, `a_hi` is 0.
- R4: The pair {`bhe_n`, A0} is 11 for a refresh cycle, whatever the byte enables. Otherwise it is 01 when only `req_be[1]` (upper byte) is set, 10 when only `req_be[0]` (lower byte) is set, and 00 for a word (both enables set or none set).
- R5: `bhe_n` holds its encoded value from T1 through T2, T3 and every TW. It is 1 in T4 and in IDLE.
- R6: Outside queue-status mode, `ale_qs0` rises at the falling clock edge of the cycle that precedes T1 and falls at the falling clock edge inside T1.
- R7: Outside queue-status mode, `wr_qs1` (active low) is 0 during all of T2, T3 and TW of a write. `rd_n` is 0 from the falling edge inside T2 through T3 and TW of a read. Both strobes are 1 in T1, T4 and IDLE, and they are never low together.
- R8: For a read, the value on `ad_in` at the clock edge that ends the last T3 or TW appears on `rdata` during T4. `done` is 1 exactly during T4.
- R9: With `qs_mode` high, `ale_qs0` shows `qs_code[0]` and `wr_qs1` shows `qs_code[1]`, each registered one clock after sampling, and the write and latch strobes are suppressed on those pins. The code means 00 no operation, 01 first opcode byte taken, 11 later byte taken, 10 queue emptied. Bus cycles and `rd_n` keep working.
- R10: `req_ready` is 1 in IDLE and T4 and 0 in T1, T2, T3 and TW.
- R11: After reset the state is IDLE: `ale_qs0`=0, `rd_n`=1, `wr_qs1`=1, `bhe_n`=1, `ad_oe`=0, `done`=0, `req_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A cycle request is offered |
| req_ready | output | 1 | Request taken at this clock edge (IDLE or T4) |
| req_addr | input | 20 | Cycle address |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_be | input | 2 | Byte enables: bit 1 upper lane, bit 0 lower lane |
| req_dma | input | 1 | Cycle is issued on behalf of DMA |
| req_refresh | input | 1 | Cycle is a memory refresh |
| req_wdata | input | 16 | Write data |
| bus_ready | input | 1 | Synchronous ready; low adds a wait state |
| qs_mode | input | 1 | Select queue-status output on the latch/write pins |
| qs_code | input | 2 | Queue operation code {qs1, qs0} |
| ale_qs0 | output | 1 | Address latch enable, or queue-status bit 0 |
| wr_qs1 | output | 1 | Write strobe (active low), or queue-status bit 1 |
| rd_n | output | 1 | Read strobe, active low |
| bhe_n | output | 1 | Upper-lane enable, active low |
| a_hi | output | 4 | Address bits 19..16 in T1, status after T1 |
| ad_out | output | 16 | Shared address/data bus, outgoing value |
| ad_oe | output | 1 | Drive enable for the shared bus |
| ad_in | input | 16 | Shared address/data bus, incoming value |
| rdata | output | 16 | Captured read data |
| done | output | 1 | Pulse during T4 |

## Verification
The bench sweeps every combination of read and write, the four byte-enable patterns, the DMA and refresh flags, and zero, one or two wait states. The lane pair then shows each encoding, including the case where refresh overrides the enables. The done pulse, which comes only after the expected number of wait states, separates a stretched cycle from a short one. The bench samples in both halves of each clock, so a latch or read strobe that is off by half a clock is told apart from one that is correct. A back-to-back pair shows T4 going straight to T1. A queue-status pass walks all four codes and runs a write and a read with the strobes suppressed.

// File: rtl/lbus_pkg.sv
package lbus_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_T1,
        ST_T2,
        ST_T3,
        ST_TW,
        ST_T4
    } bus_state_e;

    typedef struct packed {
        logic       write;
        logic [1:0] be;
        logic       dma;
        logic       refresh;
    } cyc_kind_t;

    // returns {bhe_n, a0}
    function automatic logic [1:0] lane_code(input cyc_kind_t k);
        logic [1:0] r;
        if (k.refresh)         r = 2'b11;
        else if (k.be == 2'b10) r = 2'b01;
        else if (k.be == 2'b01) r = 2'b10;
        else                   r = 2'b00;
        return r;
    endfunction

endpackage

// File: rtl/lbus_fsm.sv
module lbus_fsm
    import lbus_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  cyc_kind_t         req_kind,
    input  logic              bus_ready,
    output bus_state_e        state,
    output logic              req_ready,
    output logic              start,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [DATA_W-1:0] cur_wdata,
    output cyc_kind_t         cur_kind
);

    bus_state_e nxt;

    assign req_ready = (state == ST_IDLE) || (state == ST_T4);
    assign start     = req_ready && req_valid;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:      nxt = req_valid ? ST_T1 : ST_IDLE;
            ST_T1:        nxt = ST_T2;
            ST_T2:        nxt = ST_T3;
            ST_T3, ST_TW: nxt = bus_ready ? ST_T4 : ST_TW;
            ST_T4:        nxt = req_valid ? ST_T1 : ST_IDLE;
            default:      nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cur_addr  <= '0;
            cur_wdata <= '0;
            cur_kind  <= '0;
        end else begin
            state <= nxt;
            if (start) begin
                cur_addr  <= req_addr;
                cur_wdata <= req_wdata;
                cur_kind  <= req_kind;
            end
        end
    end

    // R1
    t1_to_t2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_T1) |=> (state == ST_T2));

    // R1
    wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_T3 || state == ST_TW) && !bus_ready) |=> (state == ST_TW));

    // R10
    accept_to_t1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_valid) |=> (state == ST_T1));

endmodule

// File: rtl/lbus_pins.sv
module lbus_pins
    import lbus_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  bus_state_e               state,
    input  logic                     start,
    input  logic [ADDR_W-1:0]        cur_addr,
    input  logic [DATA_W-1:0]        cur_wdata,
    input  cyc_kind_t                cur_kind,
    input  logic                     qs_mode,
    input  logic [1:0]               qs_code,
    output logic                     ale_qs0,
    output logic                     wr_qs1,
    output logic                     rd_n,
    output logic                     bhe_n,
    output logic [ADDR_W-DATA_W-1:0] a_hi,
    output logic [DATA_W-1:0]        ad_out,
    output logic                     ad_oe
);

    localparam int SHI_W = ADDR_W - DATA_W;

    logic       ale_q;
    logic       t2_late_q;
    logic [1:0] qs_q;
    logic       wr_raw_n;
    logic       in_t1;
    logic       in_strobe;
    logic       in_data;
    logic [1:0] lane;

    assign in_t1     = (state == ST_T1);
    assign in_strobe = (state == ST_T2) || (state == ST_T3) || (state == ST_TW);
    assign in_data   = in_strobe || (state == ST_T4);
    assign lane      = lane_code(cur_kind);

    // half-clock phase flops: launched on the falling edge
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ale_q     <= 1'b0;
            t2_late_q <= 1'b0;
        end else begin
            ale_q     <= start;
            t2_late_q <= (state == ST_T2);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) qs_q <= 2'b00;
        else        qs_q <= qs_code;
    end

    always_comb begin
        ad_oe  = in_t1 || (in_data && cur_kind.write);
        ad_out = '0;
        a_hi   = '0;
        if (in_t1) begin
            ad_out = {cur_addr[DATA_W-1:1], lane[0]};
            a_hi   = cur_addr[ADDR_W-1:DATA_W];
        end else if (in_data) begin
            if (cur_kind.write) ad_out = cur_wdata;
            a_hi = {cur_kind.dma, {(SHI_W-1){1'b0}}};
        end
    end

    assign bhe_n    = (in_t1 || in_strobe) ? lane[1] : 1'b1;
    assign wr_raw_n = !(cur_kind.write && in_strobe);
    assign rd_n     = !(!cur_kind.write &&
                        ((state == ST_T3) || (state == ST_TW) ||
                         ((state == ST_T2) && t2_late_q)));
    assign ale_qs0  = qs_mode ? qs_q[0] : ale_q;
    assign wr_qs1   = qs_mode ? qs_q[1] : wr_raw_n;

    // R7
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_raw_n));

    // R2
    read_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !ad_oe);

    // R6
    ale_leads_t1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ale_q |=> (state == ST_T1));

endmodule

// File: rtl/lbus_rdcap.sv
module lbus_rdcap
    import lbus_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bus_state_e        state,
    input  logic              is_write,
    input  logic              bus_ready,
    input  logic [DATA_W-1:0] ad_in,
    output logic [DATA_W-1:0] rdata,
    output logic              done
);

    logic last_data;

    assign last_data = ((state == ST_T3) || (state == ST_TW)) && bus_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
            done  <= 1'b0;
        end else begin
            done <= last_data;
            if (last_data && !is_write) rdata <= ad_in;
        end
    end

    // R8
    done_after_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(state) == ST_T3 || $past(state) == ST_TW));

endmodule

// File: rtl/lbus_seq.sv
module lbus_seq
    import lbus_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic                     req_write,
    input  logic [1:0]               req_be,
    input  logic                     req_dma,
    input  logic                     req_refresh,
    input  logic [DATA_W-1:0]        req_wdata,
    input  logic                     bus_ready,
    input  logic                     qs_mode,
    input  logic [1:0]               qs_code,
    output logic                     ale_qs0,
    output logic                     wr_qs1,
    output logic                     rd_n,
    output logic                     bhe_n,
    output logic [ADDR_W-DATA_W-1:0] a_hi,
    output logic [DATA_W-1:0]        ad_out,
    output logic                     ad_oe,
    input  logic [DATA_W-1:0]        ad_in,
    output logic [DATA_W-1:0]        rdata,
    output logic                     done
);

    bus_state_e        state;
    logic              start;
    logic [ADDR_W-1:0] cur_addr;
    logic [DATA_W-1:0] cur_wdata;
    cyc_kind_t         cur_kind;
    cyc_kind_t         req_kind;

    assign req_kind = '{write: req_write, be: req_be, dma: req_dma, refresh: req_refresh};

    lbus_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_kind(req_kind), .bus_ready(bus_ready),
        .state(state), .req_ready(req_ready), .start(start),
        .cur_addr(cur_addr), .cur_wdata(cur_wdata), .cur_kind(cur_kind)
    );

    lbus_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
        .clk(clk), .rst_n(rst_n), .state(state), .start(start),
        .cur_addr(cur_addr), .cur_wdata(cur_wdata), .cur_kind(cur_kind),
        .qs_mode(qs_mode), .qs_code(qs_code), .ale_qs0(ale_qs0), .wr_qs1(wr_qs1),
        .rd_n(rd_n), .bhe_n(bhe_n), .a_hi(a_hi), .ad_out(ad_out), .ad_oe(ad_oe)
    );

    lbus_rdcap #(.DATA_W(DATA_W)) u_rdcap (
        .clk(clk), .rst_n(rst_n), .state(state), .is_write(cur_kind.write),
        .bus_ready(bus_ready), .ad_in(ad_in), .rdata(rdata), .done(done)
    );

endmodule

// File: tb/lbus_seq_test.sv
`timescale 1ns/1ps
module lbus_seq_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [19:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic [1:0]  req_be = 2'b11;
    logic        req_dma = 1'b0;
    logic        req_refresh = 1'b0;
    logic [15:0] req_wdata = '0;
    logic        bus_ready = 1'b1;
    logic        qs_mode = 1'b0;
    logic [1:0]  qs_code = 2'b00;
    logic        ale_qs0, wr_qs1, rd_n, bhe_n, ad_oe, done;
    logic [3:0]  a_hi;
    logic [15:0] ad_out, rdata;
    logic [15:0] ad_in = '0;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    lbus_seq uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_write(req_write), .req_be(req_be), .req_dma(req_dma),
        .req_refresh(req_refresh), .req_wdata(req_wdata), .bus_ready(bus_ready),
        .qs_mode(qs_mode), .qs_code(qs_code), .ale_qs0(ale_qs0), .wr_qs1(wr_qs1),
        .rd_n(rd_n), .bhe_n(bhe_n), .a_hi(a_hi), .ad_out(ad_out), .ad_oe(ad_oe),
        .ad_in(ad_in), .rdata(rdata), .done(done)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [1:0] exp_lane(input logic [1:0] be, input logic rf);
        if (rf) return 2'b11;
        case (be)
            2'b10:   return 2'b01;
            2'b01:   return 2'b10;
            default: return 2'b00;
        endcase
    endfunction

    task automatic step_early();
        @(posedge clk);
        #1;
    endtask

    // Entered at the early sample of an IDLE cycle; leaves at the early sample of the following IDLE.
    task automatic run_cycle(input logic [19:0] addr, input logic wr, input logic [1:0] be,
                             input logic dma, input logic rf, input int nwait,
                             input logic [15:0] wd, input logic [15:0] rbus, input logic qsm);
        logic [1:0] ln;
        ln = exp_lane(be, rf);
        req_addr = addr; req_write = wr; req_be = be; req_dma = dma;
        req_refresh = rf; req_wdata = wd; req_valid = 1'b1;
        chk(req_ready == 1'b1, "R10 idle ready", 32'(req_ready), 1);
        #2.5;
        if (!qsm) chk(ale_qs0 == 1'b1, "R6 ale early rise", 32'(ale_qs0), 1);
        step_early(); // T1
        req_valid = 1'b0;
        if (!qsm) chk(ale_qs0 == 1'b1, "R6 ale held in T1", 32'(ale_qs0), 1);
        else chk(ale_qs0 == qs_code[0] && wr_qs1 == qs_code[1], "R9 qs pins T1", 32'({wr_qs1, ale_qs0}), 32'(qs_code));
        chk(req_ready == 1'b0, "R10 busy T1", 32'(req_ready), 0);
        chk(ad_oe == 1'b1 && ad_out == {addr[15:1], ln[0]}, "R2 T1 address", 32'(ad_out), 32'({addr[15:1], ln[0]}));
        chk(a_hi == addr[19:16], "R3 T1 upper address", 32'(a_hi), 32'(addr[19:16]));
        chk(bhe_n == ln[1], "R4 T1 bhe", 32'({bhe_n, ad_out[0]}), 32'(ln));
        chk(rd_n == 1'b1, "R7 no read T1", 32'(rd_n), 1);
        #2.5;
        if (!qsm) chk(ale_qs0 == 1'b0, "R6 ale fall in T1", 32'(ale_qs0), 0);
        step_early(); // T2
        chk(ad_oe == wr, "R2 T2 drive", 32'(ad_oe), 32'(wr));
        if (wr) chk(ad_out == wd, "R2 T2 write data", 32'(ad_out), 32'(wd));
        chk(a_hi == {dma, 3'b000}, "R3 T2 status", 32'(a_hi), 32'({dma, 3'b000}));
        chk(rd_n == 1'b1, "R7 read held off early T2", 32'(rd_n), 1);
        if (!qsm) chk(wr_qs1 == !wr, "R7 write strobe T2", 32'(wr_qs1), 32'(!wr));
        chk(bhe_n == ln[1], "R5 bhe T2", 32'(bhe_n), 32'(ln[1]));
        #2.5;
        chk(rd_n == wr, "R7 read late T2", 32'(rd_n), 32'(wr));
        step_early(); // T3
        ad_in = rbus;
        bus_ready = (nwait == 0);
        chk(rd_n == wr, "R7 read T3", 32'(rd_n), 32'(wr));
        if (!qsm) chk(wr_qs1 == !wr, "R7 write strobe T3", 32'(wr_qs1), 32'(!wr));
        else chk(wr_qs1 == qs_code[1], "R9 write strobe suppressed", 32'(wr_qs1), 32'(qs_code[1]));
        chk(bhe_n == ln[1], "R5 bhe T3", 32'(bhe_n), 32'(ln[1]));
        for (int i = 0; i < nwait; i++) begin
            step_early(); // TW
            bus_ready = (i == nwait - 1);
            chk(done == 1'b0 && rd_n == wr, "R1 wait state", 32'({done, rd_n}), 32'({1'b0, wr}));
            chk(bhe_n == ln[1], "R5 bhe TW", 32'(bhe_n), 32'(ln[1]));
            chk(req_ready == 1'b0, "R10 busy TW", 32'(req_ready), 0);
        end
        step_early(); // T4
        bus_ready = 1'b1;
        ad_in = ~rbus;
        chk(done == 1'b1, "R8 done in T4", 32'(done), 1);
        if (!wr) chk(rdata == rbus, "R8 read data", 32'(rdata), 32'(rbus));
        chk(rd_n == 1'b1, "R7 read off T4", 32'(rd_n), 1);
        if (!qsm) chk(wr_qs1 == 1'b1, "R7 write off T4", 32'(wr_qs1), 1);
        chk(bhe_n == 1'b1, "R5 bhe off T4", 32'(bhe_n), 1);
        chk(a_hi == {dma, 3'b000}, "R3 T4 status", 32'(a_hi), 32'({dma, 3'b000}));
        chk(req_ready == 1'b1, "R10 ready T4", 32'(req_ready), 1);
        step_early(); // IDLE
        chk(done == 1'b0, "R1 back to idle", 32'(done), 0);
        chk(ad_oe == 1'b0 && a_hi == 4'h0, "R2 R3 idle float", 32'({ad_oe, a_hi}), 0);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [19:0] a;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        // R11 reset state
        chk(ale_qs0 == 0 && rd_n == 1 && wr_qs1 == 1 && bhe_n == 1, "R11 strobes idle",
            32'({ale_qs0, rd_n, wr_qs1, bhe_n}), 32'b0111);
        chk(ad_oe == 0 && done == 0 && req_ready == 1, "R11 bus idle",
            32'({ad_oe, done, req_ready}), 32'b001);
        step_early();

        // Sweep: direction x enables x dma x refresh x wait states
        for (int k = 0; k < 96; k++) begin
            a = 20'(k * 20'h0B3D7 + 20'h51A2E);
            run_cycle(a, 1'(k % 2), 2'((k / 2) % 4), 1'((k / 8) % 2), 1'((k / 16) % 2),
                      (k / 32) % 3, 16'(k * 16'h1357 + 16'h0F0F), 16'(k * 16'h2468 + 16'h5A5A), 1'b0);
        end

        // Back-to-back: T4 goes straight to T1 (R1, R6, R10)
        req_addr = 20'hA5678; req_write = 1'b1; req_be = 2'b11; req_dma = 1'b0;
        req_refresh = 1'b0; req_wdata = 16'hBEEF; req_valid = 1'b1;
        step_early(); // T1
        step_early(); // T2
        step_early(); // T3
        step_early(); // T4
        chk(done == 1'b1, "R1 first T4", 32'(done), 1);
        #2.5;
        chk(ale_qs0 == 1'b1, "R6 ale rises in T4", 32'(ale_qs0), 1);
        step_early(); // T1 again
        req_valid = 1'b0;
        chk(ad_oe == 1'b1 && ad_out == 16'h5678 && a_hi == 4'hA, "R1 T4 to T1",
            32'({a_hi, ad_out}), 32'h0A5678);
        repeat (4) step_early();

        // Queue-status mode (R9)
        qs_mode = 1'b1;
        for (int c = 0; c < 4; c++) begin
            qs_code = 2'(c);
            step_early();
            chk(ale_qs0 == qs_code[0] && wr_qs1 == qs_code[1], "R9 qs code",
                32'({wr_qs1, ale_qs0}), 32'(c));
        end
        qs_code = 2'b01;
        step_early();
        run_cycle(20'h3C0DE, 1'b1, 2'b11, 1'b1, 1'b0, 1, 16'hC0DE, 16'h0000, 1'b1);
        run_cycle(20'h41234, 1'b0, 2'b01, 1'b0, 1'b0, 2, 16'h0000, 16'h7E57, 1'b1);
        qs_mode = 1'b0;

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule